// File: doc/BRIEF.md
# Memory Window Address Translator

This block sits on the address path of a bus master that fetches from memory. Every fetch address it receives is compared against six programmable windows. When an enabled window covers the address, the block returns three things: the window's target identifier, its attribute byte, and a translated address. In the translated address, the bits above the window's offset come from the window's remap value. When no enabled window covers the address, a miss is flagged, the target and attribute come back as zero, and the address passes through unchanged.

Windows are sized in 64 KiB units. Each window has a size field that holds the size minus one, and this field acts as a mask over the upper address half. A narrow write port programs three registers per window: control, base and remap. The windows' register groups sit 16 bytes apart. Each request is a single address qualified by a strobe. The block answers it exactly one cycle later with a valid pulse and a hit or miss flag. There is no back-pressure, and the block can accept one request every cycle.

Top module: `mwin_xlate`

## Requirements
- R1: After reset every window is disabled, with size, base and remap all zero. No response flag is raised until a request arrives, and a request made before any programming misses.
- R2: A window's group of registers starts at byte offset 16*w on the write port, for w from 0 to 5. Offset +0 is control, +4 is base and +12 is remap. A write to offset +8, to any other offset, or to a group with index 6 or higher changes nothing.
- R3: Control bit 0 enables the window. Bits 7:4 give the 4-bit target ID, bits 15:8 give the 8-bit attribute, and bits 31:16 give the size-minus-one mask, in 64 KiB units.
- R4: An address hits window w when the window is enabled and (addr[31:16] & ~mask) equals base[31:16]. Bits 15:0 of the base register and of the remap register are ignored.
- R5: When several windows hit, the lowest-numbered one decides the result. rsp_win reports its index.
- R6: On a hit, the translated address is {(remap[31:16] & ~mask) | (addr[31:16] & mask), addr[15:0]}. That is, the offset within the window is kept.
- R7: On a miss, rsp_miss is raised and rsp_target, rsp_attr and rsp_win are zero. rsp_addr equals the request address.
- R8: The result appears in the cycle after req_valid, with a one-cycle rsp_valid pulse. rsp_hit and rsp_miss are raised only together with rsp_valid, and exactly one of them is raised. Without a request, the result fields keep their last value.
- R9: A disabled window never hits, even when its base matches. Clearing the enable bit of a window lets a higher-numbered overlapping window take over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Fetch address to translate |
| rsp_valid | output | 1 | Result valid pulse, one cycle after req_valid |
| rsp_hit | output | 1 | An enabled window matched |
| rsp_miss | output | 1 | No enabled window matched |
| rsp_win | output | 3 | Index of the winning window |
| rsp_target | output | 4 | Target ID of the winning window |
| rsp_attr | output | 8 | Attribute byte of the winning window |
| rsp_addr | output | 32 | Translated address |

## Verification
The hardest case to reach from the ports is a true overlap: two enabled windows that both cover one address and resolve differently. The result should show that priority, rather than chance, picked the winner. The stimulus programs a 1 MiB window inside a 16 MiB window with a common base. It sends addresses inside and outside the small window. It then clears only the small window's enable bit and repeats the inner address, so the expected target and remapped upper bits switch to the large window's. Writes to the unused slot and to a seventh window group come before the table walk, so any aliasing would show up as a wrong translation.

// File: rtl/mwin_pkg.sv
package mwin_pkg;

  localparam int WIN_STRIDE_LOG2 = 4;
  localparam int CTRL_EN_BIT     = 0;
  localparam int CTRL_TGT_LSB    = 4;
  localparam int CTRL_ATTR_LSB   = 8;

  typedef enum logic [1:0] {
    SLOT_CTRL  = 2'd0,
    SLOT_BASE  = 2'd1,
    SLOT_REMAP = 2'd2,
    SLOT_NONE  = 2'd3
  } slot_e;

  function automatic slot_e slot_of(input logic [WIN_STRIDE_LOG2-1:0] off);
    case (off)
      4'h0:    return SLOT_CTRL;
      4'h4:    return SLOT_BASE;
      4'hC:    return SLOT_REMAP;
      default: return SLOT_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mwin_regfile.sv
module mwin_regfile #(
  parameter int NUM_WIN   = 6,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 16,
  parameter int TGT_W     = 4,
  parameter int ATTR_W    = 8,
  parameter int CFG_AW    = 8,
  localparam int HI_W     = ADDR_W - GRAN_BITS,
  localparam int WSEL_W   = CFG_AW - mwin_pkg::WIN_STRIDE_LOG2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [ADDR_W-1:0]             cfg_wdata,
  output logic [NUM_WIN-1:0]            win_en,
  output logic [NUM_WIN-1:0][TGT_W-1:0] win_tgt,
  output logic [NUM_WIN-1:0][ATTR_W-1:0] win_attr,
  output logic [NUM_WIN-1:0][HI_W-1:0]  win_mask,
  output logic [NUM_WIN-1:0][HI_W-1:0]  win_base,
  output logic [NUM_WIN-1:0][HI_W-1:0]  win_remap
);
  import mwin_pkg::*;

  logic [WSEL_W-1:0] wsel;
  slot_e             slot;
  logic              unused_wbits;

  assign wsel = cfg_addr[CFG_AW-1:WIN_STRIDE_LOG2];
  assign slot = slot_of(cfg_addr[WIN_STRIDE_LOG2-1:0]);
  assign unused_wbits = ^cfg_wdata;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic              sel;
    logic              ld_ctrl, ld_base, ld_remap;
    logic              en_d;
    logic [TGT_W-1:0]  tgt_d;
    logic [ATTR_W-1:0] attr_d;
    logic [HI_W-1:0]   mask_d, base_d, remap_d;

    assign sel = cfg_we && (wsel == WSEL_W'(w));

    always_comb begin
      ld_ctrl  = sel && (slot == SLOT_CTRL);
      ld_base  = sel && (slot == SLOT_BASE);
      ld_remap = sel && (slot == SLOT_REMAP);
      en_d     = cfg_wdata[CTRL_EN_BIT];
      tgt_d    = cfg_wdata[CTRL_TGT_LSB +: TGT_W];
      attr_d   = cfg_wdata[CTRL_ATTR_LSB +: ATTR_W];
      mask_d   = cfg_wdata[ADDR_W-1:GRAN_BITS];
      base_d   = cfg_wdata[ADDR_W-1:GRAN_BITS];
      remap_d  = cfg_wdata[ADDR_W-1:GRAN_BITS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_en[w]   <= 1'b0;
        win_tgt[w]  <= '0;
        win_attr[w] <= '0;
        win_mask[w] <= '0;
      end else if (ld_ctrl) begin
        win_en[w]   <= en_d;
        win_tgt[w]  <= tgt_d;
        win_attr[w] <= attr_d;
        win_mask[w] <= mask_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_base[w] <= '0;
      end else if (ld_base) begin
        win_base[w] <= base_d;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_remap[w] <= '0;
      end else if (ld_remap) begin
        win_remap[w] <= remap_d;
      end
    end
  end

endmodule

// File: rtl/mwin_match.sv
module mwin_match #(
  parameter int NUM_WIN = 6,
  parameter int HI_W    = 16
) (
  input  logic [HI_W-1:0]              addr_hi,
  input  logic [NUM_WIN-1:0]           win_en,
  input  logic [NUM_WIN-1:0][HI_W-1:0] win_mask,
  input  logic [NUM_WIN-1:0][HI_W-1:0] win_base,
  output logic [NUM_WIN-1:0]           hit_vec
);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    logic [HI_W-1:0] fixed_bits;
    assign fixed_bits = addr_hi & ~win_mask[w];
    assign hit_vec[w] = win_en[w] && (fixed_bits == win_base[w]);
  end

endmodule

// File: rtl/mwin_prio.sv
module mwin_prio #(
  parameter int NUM_WIN = 6,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic [NUM_WIN-1:0] hit_vec,
  output logic               any_hit,
  output logic [IDX_W-1:0]   win_idx
);

  always_comb begin
    any_hit = |hit_vec;
    win_idx = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_vec[i]) win_idx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/mwin_xlate.sv
module mwin_xlate #(
  parameter int NUM_WIN   = 6,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 16,
  parameter int TGT_W     = 4,
  parameter int ATTR_W    = 8,
  parameter int CFG_AW    = 8,
  localparam int HI_W     = ADDR_W - GRAN_BITS,
  localparam int IDX_W    = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic [IDX_W-1:0]  rsp_win,
  output logic [TGT_W-1:0]  rsp_target,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic [ADDR_W-1:0] rsp_addr
);

  logic [NUM_WIN-1:0]             win_en;
  logic [NUM_WIN-1:0][TGT_W-1:0]  win_tgt;
  logic [NUM_WIN-1:0][ATTR_W-1:0] win_attr;
  logic [NUM_WIN-1:0][HI_W-1:0]   win_mask, win_base, win_remap;
  logic [NUM_WIN-1:0]             hit_vec;
  logic                           any_hit;
  logic [IDX_W-1:0]               win_idx;
  logic [HI_W-1:0]                addr_hi, mask_s, remap_s, xl_hi;

  logic              valid_d, hit_d, miss_d;
  logic [IDX_W-1:0]  win_d;
  logic [TGT_W-1:0]  tgt_d;
  logic [ATTR_W-1:0] attr_d;
  logic [ADDR_W-1:0] addr_d;

  mwin_regfile #(
    .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS),
    .TGT_W(TGT_W), .ATTR_W(ATTR_W), .CFG_AW(CFG_AW)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .win_en(win_en), .win_tgt(win_tgt),
    .win_attr(win_attr), .win_mask(win_mask), .win_base(win_base),
    .win_remap(win_remap)
  );

  assign addr_hi = req_addr[ADDR_W-1:GRAN_BITS];

  mwin_match #(.NUM_WIN(NUM_WIN), .HI_W(HI_W)) u_match (
    .addr_hi(addr_hi), .win_en(win_en), .win_mask(win_mask),
    .win_base(win_base), .hit_vec(hit_vec)
  );

  mwin_prio #(.NUM_WIN(NUM_WIN)) u_prio (
    .hit_vec(hit_vec), .any_hit(any_hit), .win_idx(win_idx)
  );

  // next-state of the result stage
  always_comb begin
    mask_s  = win_mask[win_idx];
    remap_s = win_remap[win_idx];
    xl_hi   = (remap_s & ~mask_s) | (addr_hi & mask_s);
    valid_d = req_valid;
    hit_d   = req_valid && any_hit;
    miss_d  = req_valid && !any_hit;
    if (any_hit) begin
      win_d  = win_idx;
      tgt_d  = win_tgt[win_idx];
      attr_d = win_attr[win_idx];
      addr_d = {xl_hi, req_addr[GRAN_BITS-1:0]};
    end else begin
      win_d  = '0;
      tgt_d  = '0;
      attr_d = '0;
      addr_d = req_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
      rsp_miss  <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_win    <= '0;
      rsp_target <= '0;
      rsp_attr   <= '0;
      rsp_addr   <= '0;
    end else if (req_valid) begin
      rsp_win    <= win_d;
      rsp_target <= tgt_d;
      rsp_attr   <= attr_d;
      rsp_addr   <= addr_d;
    end
  end

endmodule

// File: rtl/mwin_xlate_chk.sv
module mwin_xlate_chk #(
  parameter int NUM_WIN   = 6,
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 16,
  parameter int TGT_W     = 4,
  parameter int ATTR_W    = 8,
  localparam int IDX_W    = $clog2(NUM_WIN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic              rsp_hit,
  input logic              rsp_miss,
  input logic [IDX_W-1:0]  rsp_win,
  input logic [TGT_W-1:0]  rsp_target,
  input logic [ATTR_W-1:0] rsp_attr,
  input logic [ADDR_W-1:0] rsp_addr
);

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_IDLE: assert (!rsp_valid && !rsp_hit && !rsp_miss); // R1
    end
  end

  AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R8

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R8

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1); // R8

  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit && !rsp_miss); // R8

  AST_HOLD_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(rsp_addr) && $stable(rsp_target) && $stable(rsp_attr)); // R8

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_target == '0 && rsp_attr == '0 && rsp_win == '0); // R7

  AST_MISS_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !rsp_miss || rsp_addr == $past(req_addr)); // R7

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_addr[GRAN_BITS-1:0] == $past(req_addr[GRAN_BITS-1:0])); // R6

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_win < IDX_W'(NUM_WIN)); // R5

endmodule

bind mwin_xlate mwin_xlate_chk #(
  .NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS),
  .TGT_W(TGT_W), .ATTR_W(ATTR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
  .rsp_win(rsp_win), .rsp_target(rsp_target), .rsp_attr(rsp_attr),
  .rsp_addr(rsp_addr)
);

// File: tb/mwin_xlate_tb.sv
module mwin_xlate_tb;

  typedef struct packed {
    logic [31:0] a;
    logic        hit;
    logic [2:0]  win;
    logic [3:0]  tgt;
    logic [7:0]  attr;
    logic [31:0] o;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{32'h1000_1234, 1'b1, 3'd0, 4'h3, 8'hA5, 32'h8000_1234},
    '{32'h1001_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h1001_0000},
    '{32'h2005_1234, 1'b1, 3'd1, 4'h5, 8'h11, 32'h4035_1234},
    '{32'h2050_0004, 1'b1, 3'd2, 4'h7, 8'h22, 32'h0150_0004},
    '{32'h3000_0010, 1'b0, 3'd0, 4'h0, 8'h00, 32'h3000_0010},
    '{32'h5002_ABCD, 1'b1, 3'd4, 4'hC, 8'h44, 32'h6002_ABCD},
    '{32'h5004_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h5004_0000},
    '{32'hFFFF_0042, 1'b1, 3'd5, 4'hF, 8'hFF, 32'h0000_0042},
    '{32'h200F_FFFF, 1'b1, 3'd1, 4'h5, 8'h11, 32'h403F_FFFF},
    '{32'h0000_0000, 1'b0, 3'd0, 4'h0, 8'h00, 32'h0000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_addr;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [2:0]  rsp_win;
  logic [3:0]  rsp_target;
  logic [7:0]  rsp_attr;
  logic [31:0] rsp_addr;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  mwin_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
    .rsp_win(rsp_win), .rsp_target(rsp_target), .rsp_attr(rsp_attr),
    .rsp_addr(rsp_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive one request, sample the registered result one cycle later
  task automatic lookup(input string tag, input logic [31:0] a, input logic eh,
                        input logic [2:0] ew, input logic [3:0] et,
                        input logic [7:0] ea, input logic [31:0] eo);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R8 valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " R4 hit"},   32'(rsp_hit),   32'(eh));
    chk({tag, " R7 miss"},  32'(rsp_miss),  32'(!eh));
    chk({tag, " R5 win"},   32'(rsp_win),   32'(ew));
    chk({tag, " R3 target"},32'(rsp_target),32'(et));
    chk({tag, " R3 attr"},  32'(rsp_attr),  32'(ea));
    chk({tag, " R6 addr"},  rsp_addr,       eo);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired R8 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    req_valid = 1'b0; req_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: quiet after reset, unprogrammed windows miss
    chk("R1 valid after reset", 32'(rsp_valid), 32'd0);
    chk("R1 hit after reset",   32'(rsp_hit),   32'd0);
    chk("R1 miss after reset",  32'(rsp_miss),  32'd0);
    lookup("R1 unprogrammed", 32'h1000_1234, 1'b0, 3'd0, 4'h0, 8'h00, 32'h1000_1234);

    // program windows: ctrl = {mask, attr, tgt, 3'b0, en}
    cfg_write(8'h00, 32'h0000_A531); cfg_write(8'h04, 32'h1000_0000); cfg_write(8'h0C, 32'h8000_0000);
    cfg_write(8'h10, 32'h000F_1151); cfg_write(8'h14, 32'h2000_0000); cfg_write(8'h1C, 32'h4030_0000);
    cfg_write(8'h20, 32'h00FF_2271); cfg_write(8'h24, 32'h2000_0000); cfg_write(8'h2C, 32'h0100_0000);
    cfg_write(8'h30, 32'h0000_9990); cfg_write(8'h34, 32'h3000_0000); cfg_write(8'h3C, 32'hFFFF_0000);
    cfg_write(8'h40, 32'h0003_44C1); cfg_write(8'h44, 32'h5000_FFFF); cfg_write(8'h4C, 32'h6000_1234);
    cfg_write(8'h50, 32'h0000_FFF1); cfg_write(8'h54, 32'hFFFF_0000); cfg_write(8'h5C, 32'h0000_0000);
    // R2: writes that must change nothing
    cfg_write(8'h08, 32'hFFFF_FFFF);
    cfg_write(8'h02, 32'hFFFF_FFF0);
    cfg_write(8'h60, 32'hFFFF_FFF1);
    cfg_write(8'h6C, 32'hDEAD_0000);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      lookup($sformatf("vec%0d", i), VT[i].a, VT[i].hit, VT[i].win,
             VT[i].tgt, VT[i].attr, VT[i].o);
    end

    // R8: idle cycle keeps fields, no flags
    @(negedge clk);
    chk("R8 idle valid", 32'(rsp_valid), 32'd0);
    chk("R8 idle flags", 32'({rsp_hit, rsp_miss}), 32'd0);
    chk("R8 idle hold",  rsp_addr, 32'h0000_0000);

    // R9: disable window 1, overlapping window 2 takes over
    cfg_write(8'h10, 32'h000F_1150);
    lookup("R9 overlap fallback", 32'h2005_1234, 1'b1, 3'd2, 4'h7, 8'h22, 32'h0105_1234);

    // R2: base write to window 0 moves it
    cfg_write(8'h04, 32'h7000_0000);
    lookup("R2 base moved old", 32'h1000_1234, 1'b0, 3'd0, 4'h0, 8'h00, 32'h1000_1234);
    lookup("R2 base moved new", 32'h7000_0008, 1'b1, 3'd0, 4'h3, 8'hA5, 32'h8000_0008);

    // R8: back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h5002_0001;
    @(negedge clk);
    req_addr = 32'hFFFF_0002;
    chk("R8 b2b first", rsp_addr, 32'h6002_0001);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 b2b second", rsp_addr, 32'h0000_0002);
    chk("R8 b2b valid", 32'(rsp_valid), 32'd1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule